// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave end of a three-wire host link that reads and writes a bank of sixteen 8-bit control registers. The host lowers an active-low frame enable and toggles a serial clock. It exchanges bits over one data line, which the pad ring splits into an input, an output and an output enable. The serial clock, the enable and the incoming data are brought into the faster system clock through synchronizer chains. Clock edges are detected there, and every register update takes place in the system clock domain.

A frame opens with a header byte. The header holds a direction flag (1 = read, 0 = write), a 3-bit device identifier and a 4-bit register address, and all fields go MSB first. In a write, eight data bits follow MSB first. The write is committed only once the sixteenth falling edge has been seen. In a read, the slave takes the line at the first rising edge after the eighth falling edge. It then launches one bit per rising edge, MSB first, so the host can sample each bit on the following falling edge. A header whose identifier does not match the configured one leaves the line undriven and the registers untouched.

Top module: `serial_reg_port`

## Requirements
- R1: After reset every register reads back as 0x00 and the data output enable is low.
- R2: Each bit is sampled on a falling serial-clock edge. Header bit 7 is the direction flag (1 = read, 0 = write), bits 6..4 are the identifier and bits 3..0 the register address, sent MSB first. Data bytes are also sent MSB first.
- R3: A write frame with a matching identifier stores its data byte in the addressed register on the sixteenth falling edge.
- R4: A read frame with a matching identifier returns the addressed register MSB first, with one bit driven per rising edge starting at the first rising edge after the eighth falling edge.
- R5: A write frame that ends before its sixteenth falling edge leaves every register unchanged. Falling edges after the sixteenth within one frame have no effect.
- R6: The output enable is high only from the first rising edge after the eighth falling edge of a matching read frame until the enable line goes high.
- R7: A frame whose identifier differs from the device identifier (default 5) never raises the output enable and writes nothing.
- R8: During a read, the data output changes only after rising edges, and the output enable stays high between bits with no gap.
- R9: Raising the enable line aborts the frame, clears the bit count and drops the output enable, so the next frame is decoded from its first bit.
- R10: If the serial clock is already high when the enable falls, its first falling edge is taken as the direction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, clears registers |
| frameEnN | input | 1 | Active-low frame enable from host |
| serClk | input | 1 | Serial clock from host |
| serDataIn | input | 1 | Data line as seen at the pad input |
| serDataOut | output | 1 | Data driven toward the pad |
| serDataOe | output | 1 | Pad output enable for the data line |

## Verification
The hardest cases to reach from the ports are the frames that end at the wrong point. One is a write cut off after twelve edges, where nothing may change. Another is a frame with extra clocks past the sixteenth edge, and the third is a read aborted in the middle of its data phase. The bench uses one frame task with a selectable number of falling edges and a selectable clock idle level. It runs each broken frame and then reads the register back with a full frame. This shows both that the state is unchanged and that the counter restarts cleanly.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef struct packed {
    logic shiftIn;
    logic hdrLatch;
    logic wrCommit;
    logic loadOut;
    logic shiftOut;
  } srpStrobes_t;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stageQ[s] <= RESET_VAL;
    end else begin
      stageQ[0] <= din;
      for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
    end
  end

  assign dout = stageQ[STAGES-1];
endmodule

// File: rtl/srp_ctrl.sv
module srp_ctrl
  import srp_pkg::*;
#(
  parameter int HDR_W = 8,
  parameter int FRAME_BITS = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enSync,
  input  logic             clkSync,
  input  logic             hdrRead,
  input  logic             hdrMatch,
  output srpStrobes_t      strobes,
  output logic [CNT_W-1:0] bitCnt,
  output logic             riseEdge,
  output logic             fallEdge,
  output logic             dataOe
);
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] HDR_DONE = CNT_W'(HDR_W);
  localparam logic [CNT_W-1:0] FRM_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FRM_DONE = CNT_W'(FRAME_BITS);

  logic clkPrev;
  logic frameOn;
  logic cntFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkPrev <= 1'b0;
    else       clkPrev <= clkSync;
  end

  assign fallEdge = clkPrev & ~clkSync;
  assign riseEdge = ~clkPrev & clkSync;
  assign frameOn  = ~enSync;
  assign cntFall  = frameOn && fallEdge && (bitCnt < FRM_DONE);

  always_comb begin
    strobes          = '0;
    strobes.shiftIn  = cntFall;
    strobes.hdrLatch = cntFall && (bitCnt == HDR_LAST);
    strobes.wrCommit = cntFall && (bitCnt == FRM_LAST) && !hdrRead && hdrMatch;
    strobes.loadOut  = frameOn && riseEdge && (bitCnt == HDR_DONE) &&
                       hdrRead && hdrMatch && !dataOe;
    strobes.shiftOut = frameOn && riseEdge && dataOe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      dataOe <= 1'b0;
    end else if (!frameOn) begin
      bitCnt <= '0;
      dataOe <= 1'b0;
    end else begin
      if (cntFall) bitCnt <= bitCnt + 1'b1;
      if (strobes.loadOut) dataOe <= 1'b1;
    end
  end
endmodule

// File: rtl/srp_datapath.sv
module srp_datapath
  import srp_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W = 8,
  parameter int ID_W = 3,
  parameter int ADDR_W = 4,
  parameter int HDR_W = 8,
  parameter logic [ID_W-1:0] DEV_ID = 3'd5
) (
  input  logic        clk,
  input  logic        rstN,
  input  srpStrobes_t strobes,
  input  logic        dataSync,
  output logic        hdrRead,
  output logic        hdrMatch,
  output logic        outBit
);
  localparam int SH_W = (HDR_W > DATA_W) ? HDR_W : DATA_W;

  logic [DATA_W-1:0] regBank [NUM_REGS];
  logic [SH_W-1:0]   shiftReg;
  logic [SH_W-1:0]   nextShift;
  logic [HDR_W-1:0]  hdr;
  logic [DATA_W-1:0] outShift;
  logic [ADDR_W-1:0] hdrAddr;
  logic [ID_W-1:0]   hdrId;

  assign nextShift = {shiftReg[SH_W-2:0], dataSync};
  assign hdrRead   = hdr[HDR_W-1];
  assign hdrId     = hdr[HDR_W-2 -: ID_W];
  assign hdrAddr   = hdr[ADDR_W-1:0];
  assign hdrMatch  = (hdrId == DEV_ID);
  assign outBit    = outShift[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      hdr      <= '0;
    end else begin
      if (strobes.shiftIn)  shiftReg <= nextShift;
      if (strobes.hdrLatch) hdr      <= nextShift[HDR_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gRegs
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regBank[g] <= '0;
      else if (strobes.wrCommit && (hdrAddr == ADDR_W'(g)))
        regBank[g] <= nextShift[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outShift <= '0;
    else if (strobes.loadOut)  outShift <= regBank[hdrAddr];
    else if (strobes.shiftOut) outShift <= {outShift[DATA_W-2:0], 1'b0};
  end
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
  import srp_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W = 8,
  parameter int ID_W = 3,
  parameter logic [ID_W-1:0] DEV_ID = 3'd5,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic frameEnN,
  input  logic serClk,
  input  logic serDataIn,
  output logic serDataOut,
  output logic serDataOe
);
  localparam int ADDR_W     = $clog2(NUM_REGS);
  localparam int HDR_W      = 1 + ID_W + ADDR_W;
  localparam int FRAME_BITS = HDR_W + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  logic             enSync, clkSync, dataSync;
  logic             hdrRead, hdrMatch, outBit, dataOe;
  logic             riseEdge, fallEdge;
  logic [CNT_W-1:0] bitCnt;
  srpStrobes_t      strobes;

  srp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) u_sync (
    .clk(clk), .rstN(rstN),
    .din({frameEnN, serClk, serDataIn}),
    .dout({enSync, clkSync, dataSync})
  );

  srp_ctrl #(.HDR_W(HDR_W), .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enSync(enSync), .clkSync(clkSync),
    .hdrRead(hdrRead), .hdrMatch(hdrMatch), .strobes(strobes),
    .bitCnt(bitCnt), .riseEdge(riseEdge), .fallEdge(fallEdge), .dataOe(dataOe)
  );

  srp_datapath #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ID_W(ID_W),
                 .ADDR_W(ADDR_W), .HDR_W(HDR_W), .DEV_ID(DEV_ID)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataSync(dataSync),
    .hdrRead(hdrRead), .hdrMatch(hdrMatch), .outBit(outBit)
  );

  assign serDataOut = outBit;
  assign serDataOe  = dataOe;
endmodule

// File: rtl/serial_reg_port_chk.sv
module serial_reg_port_chk #(
  parameter int CNT_W = 5,
  parameter int HDR_W = 8,
  parameter int FRAME_BITS = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             enSync,
  input logic             riseEdge,
  input logic [CNT_W-1:0] bitCnt,
  input logic             serDataOe,
  input logic             serDataOut
);
  AST_OE_DROP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    enSync |=> !serDataOe); // R9
  AST_CNT_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    enSync |=> (bitCnt == '0)); // R9
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(FRAME_BITS)); // R5
  AST_OE_AFTER_HDR: assert property (@(posedge clk) disable iff (!rstN)
    serDataOe |-> (bitCnt >= CNT_W'(HDR_W))); // R6
  AST_OE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(serDataOe) |-> $past(riseEdge)); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (serDataOe && $past(serDataOe) && !$past(riseEdge)) |-> $stable(serDataOut)); // R8
endmodule

bind serial_reg_port serial_reg_port_chk u_chk (.*);

// File: tb/serial_reg_port_tb.sv
module serial_reg_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameEnN = 1'b1;
  logic serClk = 1'b0;
  logic serDataIn = 1'b0;
  logic serDataOut, serDataOe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  serial_reg_port u_dut (
    .clk(clk), .rstN(rstN), .frameEnN(frameEnN), .serClk(serClk),
    .serDataIn(serDataIn), .serDataOut(serDataOut), .serDataOe(serDataOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One frame: header {rw,id,addr} then data, nFalls falling edges.
  task automatic xfer(input logic rw, input logic [2:0] id, input logic [3:0] addr,
                      input logic [7:0] wd, input int nFalls, input logic idleHigh,
                      output logic [7:0] rd, output int oeEarly, output int oeHigh,
                      output int holdBad);
    logic [15:0] bits;
    bits = {rw, id, addr, wd};
    rd = '0; oeEarly = 0; oeHigh = 0; holdBad = 0;
    @(negedge clk);
    serClk = idleHigh;
    repeat (4) @(negedge clk);
    frameEnN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nFalls; i++) begin
      serClk = 1'b1;
      serDataIn = (i < 16) ? bits[15-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (i >= 8 && i < 16) begin
        rd[15-i] = serDataOut;
        if (serDataOe) oeHigh++;
      end else if (i < 8 && serDataOe) begin
        oeEarly++;
      end
      serClk = 1'b0;
      repeat (HALF/2) @(negedge clk);
      if (i >= 8 && i < 16 && serDataOut !== rd[15-i]) holdBad++;
      repeat (HALF/2) @(negedge clk);
    end
    frameEnN = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic readReg(input logic [3:0] addr, input logic idleHigh, output logic [7:0] rd);
    int e, h, b;
    xfer(1'b1, 3'd5, addr, 8'h00, 16, idleHigh, rd, e, h, b);
  endtask

  task automatic writeReg(input logic [3:0] addr, input logic [7:0] wd, input logic idleHigh);
    logic [7:0] rd;
    int e, h, b;
    xfer(1'b0, 3'd5, addr, wd, 16, idleHigh, rd, e, h, b);
  endtask

  task automatic testReset();
    logic [7:0] rd;
    check("R1", "oe after reset", serDataOe, 1'b0);
    readReg(4'd5, 1'b0, rd);
    check("R1", "reg5 after reset", rd, 8'h00);
    readReg(4'd15, 1'b0, rd);
    check("R1", "reg15 after reset", rd, 8'h00);
  endtask

  task automatic testWriteRead();
    logic [7:0] rd;
    int e, h, b;
    writeReg(4'd3, 8'hA5, 1'b0);
    xfer(1'b1, 3'd5, 4'd3, 8'h00, 16, 1'b0, rd, e, h, b);
    check("R3", "reg3 readback", rd, 8'hA5);
    check("R6", "oe before header end", e, 0);
    check("R8", "oe high across 8 read bits", h, 8);
    check("R8", "output held through low phase", b, 0);
    check("R9", "oe released after frame", serDataOe, 1'b0);
  endtask

  task automatic testPatterns();
    logic [7:0] rd;
    writeReg(4'd0, 8'h3C, 1'b0);
    writeReg(4'd15, 8'h81, 1'b0);
    readReg(4'd0, 1'b0, rd);
    check("R2", "reg0 msb-first 3C", rd, 8'h3C);
    readReg(4'd15, 1'b0, rd);
    check("R4", "reg15 81", rd, 8'h81);
    readReg(4'd3, 1'b0, rd);
    check("R2", "reg3 unaffected by other addresses", rd, 8'hA5);
  endtask

  task automatic testShortAndLong();
    logic [7:0] rd;
    int e, h, b;
    xfer(1'b0, 3'd5, 4'd3, 8'hFF, 12, 1'b0, rd, e, h, b);
    readReg(4'd3, 1'b0, rd);
    check("R5", "short write ignored", rd, 8'hA5);
    xfer(1'b0, 3'd5, 4'd7, 8'h5A, 20, 1'b0, rd, e, h, b);
    readReg(4'd7, 1'b0, rd);
    check("R5", "extra falls after 16th ignored", rd, 8'h5A);
  endtask

  task automatic testWrongId();
    logic [7:0] rd;
    int e, h, b;
    xfer(1'b0, 3'd2, 4'd3, 8'h00, 16, 1'b0, rd, e, h, b);
    readReg(4'd3, 1'b0, rd);
    check("R7", "write with other id ignored", rd, 8'hA5);
    xfer(1'b1, 3'd4, 4'd3, 8'h00, 16, 1'b0, rd, e, h, b);
    check("R7", "read with other id never drives", h + e, 0);
  endtask

  task automatic testIdleHigh();
    logic [7:0] rd;
    writeReg(4'd9, 8'hC3, 1'b1);
    readReg(4'd9, 1'b1, rd);
    check("R10", "idle-high clock write/read", rd, 8'hC3);
  endtask

  task automatic testAbortRead();
    logic [7:0] rd;
    int e, h, b;
    xfer(1'b1, 3'd5, 4'd15, 8'h00, 11, 1'b0, rd, e, h, b);
    check("R4", "partial read top bits", rd[7:5], 3'b100);
    check("R9", "oe dropped after abort", serDataOe, 1'b0);
    readReg(4'd9, 1'b0, rd);
    check("R9", "next frame decoded from scratch", rd, 8'hC3);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testWriteRead();
    testPatterns();
    testShortAndLong();
    testWrongId();
    testIdleHigh();
    testAbortRead();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule